// File: doc/BRIEF.md
# Raster Line Interrupt Counter

This block raises a programmable interrupt every few raster lines. A down-counter is loaded from an 8-bit reload value. It moves only on a line-advance pulse, which arrives together with the line number the raster has just moved to. On lines past the first blanking line, the counter is held at the reload value. On visible lines it counts down. When a visible-line event finds the counter at zero, it raises a pending flag and loads the reload value again in the same event.

The pending flag is kept whether or not interrupts are enabled. The request output is the pending flag masked by the enable input. The flag clears when the consumer acknowledges it. When the flag is raised, the block also stores the value of a free-running time input. Delivery logic can then measure latency from the moment the interrupt was raised, not from the moment it is serviced.

Top module: `hint_line_irq`

## Requirements
- R1: After reset, `pending` and `irq` are 0, `pend_stamp` is 0 and the internal counter is 0. The first visible-line event after reset therefore raises `pending`.
- R2: A line-advance whose `line_num` is strictly greater than `first_inactive` loads the counter from `reload_val` and never raises `pending`.
- R3: A line-advance whose `line_num` is at most `first_inactive`, with a nonzero counter, decrements the counter by one and does not raise `pending`.
- R4: A line-advance whose `line_num` is at most `first_inactive`, with the counter at zero, sets `pending` on the next clock edge and loads the counter from `reload_val` in the same event.
- R5: With a reload value N held constant from a blanking line onward, `pending` is raised on every (N+1)-th visible-line event. Across visible lines 0 to F, that gives floor((F+1)/(N+1)) raises, and a value of 0 raises it on every visible line.
- R6: `irq` equals `pending` while `irq_en` is 1 and is 0 while `irq_en` is 0. `irq_en` has no effect on `pending` or on the counter.
- R7: `irq_ack` clears `pending` on the next clock edge when no raise happens in the same cycle.
- R8: When a raise and `irq_ack` occur in the same cycle, `pending` is 1 after the edge.
- R9: On every raise, `pend_stamp` takes the value `cycle_stamp` had in the cycle of that line-advance, and holds it until the next raise.
- R10: Cycles without `line_adv` leave the counter and `pending` untouched, whatever `line_num`, `first_inactive` and `reload_val` do. Only `irq_ack` can clear `pending` in such a cycle.
- R11: A line-advance with `line_num` equal to `first_inactive` counts as a visible line: it decrements the counter or raises `pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_adv | input | 1 | One-cycle pulse: the raster moved to `line_num` |
| line_num | input | LINE_W (9) | Line number after the advance |
| first_inactive | input | LINE_W (9) | First blanking line number |
| reload_val | input | CNT_W (8) | Counter reload value |
| irq_en | input | 1 | Interrupt request enable |
| irq_ack | input | 1 | Clears the pending flag |
| cycle_stamp | input | TIME_W (16) | Free-running time value |
| pending | output | 1 | Pending line interrupt |
| irq | output | 1 | `pending` masked by `irq_en` |
| pend_stamp | output | TIME_W (16) | Time of the most recent raise |

## Verification
The assertions cover the rules that act on every cycle:
- blanking lines never raise the flag;
- a visible line with a nonzero counter decrements it;
- idle cycles leave the counter alone;
- a disabled request stays low;
- a raise wins over an acknowledge;
- an acknowledge clears the flag;
- the time stamp is captured at the raise.

Only the bench scenarios can show the interrupt period for a given reload value counted over a whole frame. The same holds for the boundary line equal to the first blanking line and for the counter value left behind after reset.

// File: rtl/hint_pkg.sv
package hint_pkg;

    // What a line-advance does to the counter
    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,   // no line advance this cycle
        EV_BLANK  = 2'd1,   // blanking line: forced reload
        EV_DEC    = 2'd2,   // visible line, counter nonzero
        EV_FIRE   = 2'd3    // visible line, counter zero: raise and reload
    } line_ev_e;

    function automatic line_ev_e classify_line(
        input logic adv,
        input logic past_active,
        input logic cnt_is_zero
    );
        if (!adv)             return EV_IDLE;
        else if (past_active) return EV_BLANK;
        else if (!cnt_is_zero) return EV_DEC;
        else                  return EV_FIRE;
    endfunction

endpackage

// File: rtl/hint_line_classify.sv
module hint_line_classify
    import hint_pkg::*;
#(
    parameter int LINE_W = 9
) (
    input  logic              line_adv,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] first_inactive,
    input  logic              cnt_zero,
    output line_ev_e          ev,
    output logic              fire
);

    logic in_blank;

    always_comb begin
        // the first blanking line itself still counts as visible
        in_blank = (line_num > first_inactive);
        ev       = classify_line(line_adv, in_blank, cnt_zero);
        fire     = (ev == EV_FIRE);
    end

endmodule

// File: rtl/hint_down_counter.sv
module hint_down_counter
    import hint_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_ev_e         ev,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_zero
);

    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_RST  = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (ev)
            EV_BLANK, EV_FIRE: st_d.cnt = reload_val;
            EV_DEC:            st_d.cnt = st_q.cnt - CNT_ONE;
            default:           st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: CNT_RST};
        else        st_q <= st_d;
    end

    assign cnt_q    = st_q.cnt;
    assign cnt_zero = (st_q.cnt == '0);

endmodule

// File: rtl/hint_pending_flag.sv
module hint_pending_flag #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              ack,
    input  logic [TIME_W-1:0] stamp_in,
    output logic              pend_q,
    output logic [TIME_W-1:0] stamp_q
);

    typedef struct packed {
        logic              pend;
        logic [TIME_W-1:0] stamp;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            // raising wins over a same-cycle acknowledge
            st_d.pend  = 1'b1;
            st_d.stamp = stamp_in;
        end else if (ack) begin
            st_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q  = st_q.pend;
    assign stamp_q = st_q.stamp;

endmodule

// File: rtl/hint_line_irq.sv
module hint_line_irq
    import hint_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 9,
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_adv,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] first_inactive,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              irq_en,
    input  logic              irq_ack,
    input  logic [TIME_W-1:0] cycle_stamp,
    output logic              pending,
    output logic              irq,
    output logic [TIME_W-1:0] pend_stamp
);

    line_ev_e         ev_w;
    logic             fire_w;
    logic             cnt_zero_w;
    logic [CNT_W-1:0] cnt_w;
    logic             pend_w;

    hint_line_classify #(.LINE_W(LINE_W)) u_class (
        .line_adv       (line_adv),
        .line_num       (line_num),
        .first_inactive (first_inactive),
        .cnt_zero       (cnt_zero_w),
        .ev             (ev_w),
        .fire           (fire_w)
    );

    hint_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev_w),
        .reload_val (reload_val),
        .cnt_q      (cnt_w),
        .cnt_zero   (cnt_zero_w)
    );

    hint_pending_flag #(.TIME_W(TIME_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire_w),
        .ack      (irq_ack),
        .stamp_in (cycle_stamp),
        .pend_q   (pend_w),
        .stamp_q  (pend_stamp)
    );

    assign pending = pend_w;
    assign irq     = pend_w & irq_en;

endmodule

// File: rtl/hint_line_irq_chk.sv
module hint_line_irq_chk #(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 9,
    parameter int TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_adv,
    input logic [LINE_W-1:0] line_num,
    input logic [LINE_W-1:0] first_inactive,
    input logic              irq_en,
    input logic              irq_ack,
    input logic [TIME_W-1:0] cycle_stamp,
    input logic              pending,
    input logic              irq,
    input logic [TIME_W-1:0] pend_stamp,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              fire
);

    // R2
    blank_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv && (line_num > first_inactive) && !pending) |=> !pending);

    // R3
    visible_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv && (line_num <= first_inactive) && (cnt_q != '0))
        |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !fire) |=> !pending);

    // R8
    raise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pending);

    // R9
    stamp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pend_stamp == $past(cycle_stamp)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_adv |=> ($stable(cnt_q) && (pending || !$past(pending) || $past(irq_ack))));

endmodule

bind hint_line_irq hint_line_irq_chk #(
    .CNT_W(CNT_W), .LINE_W(LINE_W), .TIME_W(TIME_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_adv       (line_adv),
    .line_num       (line_num),
    .first_inactive (first_inactive),
    .irq_en         (irq_en),
    .irq_ack        (irq_ack),
    .cycle_stamp    (cycle_stamp),
    .pending        (pending),
    .irq            (irq),
    .pend_stamp     (pend_stamp),
    .cnt_q          (cnt_w),
    .fire           (fire_w)
);

// File: tb/sim_hint_line_irq.sv
module sim_hint_line_irq;

    localparam int CNT_W  = 8;
    localparam int LINE_W = 9;
    localparam int TIME_W = 16;
    localparam logic [LINE_W-1:0] FI = 9'd20;   // first blanking line
    localparam int LAST_LINE = 29;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_adv = 1'b0;
    logic [LINE_W-1:0] line_num = '0;
    logic [LINE_W-1:0] first_inactive = FI;
    logic [CNT_W-1:0]  reload_val = '0;
    logic              irq_en = 1'b1;
    logic              irq_ack = 1'b0;
    logic [TIME_W-1:0] cycle_stamp = '0;
    logic              pending;
    logic              irq;
    logic [TIME_W-1:0] pend_stamp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    int              m_cnt   = 0;
    bit              m_pend  = 1'b0;
    logic [TIME_W-1:0] m_stamp = '0;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cycle_stamp <= cycle_stamp + 1'b1;

    hint_line_irq #(.CNT_W(CNT_W), .LINE_W(LINE_W), .TIME_W(TIME_W)) u0 (
        .clk(clk), .rst_n(rst_n), .line_adv(line_adv), .line_num(line_num),
        .first_inactive(first_inactive), .reload_val(reload_val),
        .irq_en(irq_en), .irq_ack(irq_ack), .cycle_stamp(cycle_stamp),
        .pending(pending), .irq(irq), .pend_stamp(pend_stamp)
    );

    // stimulus vectors: adv, line, reload, ack, en
    typedef struct packed {
        logic              adv;
        logic [LINE_W-1:0] line;
        logic [CNT_W-1:0]  rel;
        logic              ack;
        logic              en;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{1'b1, 9'd1,  8'd2, 1'b0, 1'b1},
        '{1'b1, 9'd2,  8'd2, 1'b1, 1'b1},
        '{1'b1, 9'd3,  8'd2, 1'b0, 1'b1},
        '{1'b1, 9'd4,  8'd2, 1'b0, 1'b1},
        '{1'b0, 9'd50, 8'd9, 1'b0, 1'b0},
        '{1'b1, 9'd25, 8'd3, 1'b1, 1'b1},
        '{1'b1, 9'd26, 8'd3, 1'b0, 1'b1},
        '{1'b1, 9'd0,  8'd3, 1'b0, 1'b0},
        '{1'b1, 9'd1,  8'd3, 1'b0, 1'b0},
        '{1'b1, 9'd2,  8'd3, 1'b0, 1'b1},
        '{1'b1, 9'd3,  8'd0, 1'b0, 1'b1},
        '{1'b1, 9'd4,  8'd0, 1'b1, 1'b1},
        '{1'b0, 9'd4,  8'd0, 1'b1, 1'b1},
        '{1'b1, 9'd21, 8'd1, 1'b0, 1'b1},
        '{1'b1, 9'd20, 8'd1, 1'b0, 1'b1},
        '{1'b1, 9'd19, 8'd1, 1'b0, 0'b1 ? 1'b1 : 1'b1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, model update, and comparison after the edge
    task automatic step(input bit adv, input logic [LINE_W-1:0] ln,
                        input logic [CNT_W-1:0] rel, input bit ack,
                        input bit en, input string tag);
        bit fire;
        @(negedge clk);
        line_adv = adv; line_num = ln; reload_val = rel; irq_ack = ack; irq_en = en;
        fire = 1'b0;
        if (adv) begin
            if (ln > FI)         m_cnt = int'(rel);
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
            else begin fire = 1'b1; m_cnt = int'(rel); end
        end
        if (fire) begin m_pend = 1'b1; m_stamp = cycle_stamp; end
        else if (ack) m_pend = 1'b0;
        @(posedge clk);
        #5;
        check(pending == m_pend, {tag, " pending"}, pending, m_pend);
        check(irq == (m_pend & en), {tag, " irq"}, irq, m_pend & en);
        check(pend_stamp == m_stamp, {tag, " stamp"}, pend_stamp, m_stamp);
        @(negedge clk);
        line_adv = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; line_adv = 1'b0; irq_ack = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        m_cnt = 0; m_pend = 1'b0; m_stamp = '0;
        check(pending == 1'b0, "R1 pending after reset", pending, 0);
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        check(pend_stamp == '0, "R1 stamp after reset", pend_stamp, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // a full frame with a fixed reload value and acknowledge every line
    task automatic sweep(input logic [CNT_W-1:0] n);
        int raises = 0;
        int blank_hits = 0;
        int exp_raises;
        for (int l = 25; l <= LAST_LINE; l++) step(1'b1, LINE_W'(l), n, 1'b1, 1'b1, "R2 sweep blank");
        for (int l = 0; l <= LAST_LINE; l++) begin
            step(1'b1, LINE_W'(l), n, 1'b1, 1'b1, "R5 sweep");
            if (pending) begin
                if (l > int'(FI)) blank_hits++;
                else raises++;
            end
        end
        exp_raises = (int'(FI) + 1) / (int'(n) + 1);
        check(raises == exp_raises, "R5 raises per frame", raises, exp_raises);
        check(blank_hits == 0, "R2 raises in blanking", blank_hits, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: counter left at zero, so the first visible line raises
        step(1'b1, 9'd1, 8'd4, 1'b0, 1'b1, "R1 first line");
        check(pending == 1'b1, "R1 first visible raise", pending, 1);

        do_reset();
        for (int i = 0; i < 16; i++)
            step(VEC[i].adv, VEC[i].line, VEC[i].rel, VEC[i].ack, VEC[i].en, "R4 R6 table");

        // R11: line equal to first blanking line counts as visible
        do_reset();
        step(1'b1, FI, 8'd3, 1'b0, 1'b1, "R11 boundary");
        check(pending == 1'b1, "R11 boundary raise", pending, 1);

        // R3: counter now 3, three decrements without a raise
        step(1'b1, 9'd2, 8'd3, 1'b1, 1'b1, "R3 dec");
        step(1'b1, 9'd3, 8'd3, 1'b0, 1'b1, "R3 dec");
        step(1'b1, 9'd4, 8'd3, 1'b0, 1'b1, "R3 dec");
        check(pending == 1'b0, "R3 no raise while nonzero", pending, 0);

        // R10: idle cycles with noisy inputs must not move the counter
        step(1'b0, 9'd100, 8'd0, 1'b0, 1'b1, "R10 idle");
        step(1'b0, 9'd0,   8'd7, 1'b0, 1'b1, "R10 idle");
        check(pending == 1'b0, "R10 idle keeps flag", pending, 0);

        // R4 and R8: next visible line raises, with acknowledge in same cycle
        step(1'b1, 9'd5, 8'd2, 1'b1, 1'b1, "R8 raise with ack");
        check(pending == 1'b1, "R8 raise wins", pending, 1);
        check(pend_stamp == m_stamp, "R9 stamp at raise", pend_stamp, m_stamp);

        // R6: masked request keeps pending
        step(1'b0, 9'd5, 8'd2, 1'b0, 1'b0, "R6 masked");
        check(irq == 1'b0 && pending == 1'b1, "R6 mask only gates irq", irq, 0);

        // R9: stamp holds while idle
        step(1'b0, 9'd5, 8'd2, 1'b0, 1'b1, "R9 hold");
        check(pend_stamp == m_stamp, "R9 stamp held", pend_stamp, m_stamp);

        // R7: acknowledge alone clears
        step(1'b0, 9'd5, 8'd2, 1'b1, 1'b1, "R7 ack");
        check(pending == 1'b0, "R7 ack clears", pending, 0);

        // R4: counter reloaded to 2 on the raise, so the third line raises again
        step(1'b1, 9'd6, 8'd2, 1'b0, 1'b1, "R4 reload");
        step(1'b1, 9'd7, 8'd2, 1'b0, 1'b1, "R4 reload");
        check(pending == 1'b0, "R4 not yet", pending, 0);
        step(1'b1, 9'd8, 8'd2, 1'b0, 1'b1, "R4 reload");
        check(pending == 1'b1, "R4 raise after reload", pending, 1);

        // R5 and R2: whole frames
        sweep(8'd0);
        sweep(8'd3);
        sweep(8'd4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule